// File: doc/BRIEF.md
# Calibrating Bit-Rate Detector and Tick Generator

This block listens to a single-wire, half-duplex serial debug line and learns the host's bit rate from a fixed calibration character. The host sends the byte 80h. Sent least significant bit first, it shows up on the line as a start bit and seven zero data bits, so the line stays low for eight bit times and then goes high. The block counts how many system clocks the line stays low and divides the count by eight. The result is the bit period in system clocks. From then on the block holds that period and produces a bit-boundary tick and a mid-bit sample strobe. A companion transmitter and receiver use these to frame characters.

The line input passes through a two-flop synchronizer before any edge detection. Any bit period from 1 up to 512 system clocks can be learned. Two events drop the learned rate. The first is a line break: the line stays low for ten bit periods or longer. The second is a low interval long enough to overflow the measurement counter. After either event the block waits for the line to return high and then for a fresh calibration character. Framing and command decoding belong to other blocks.

Top module: `autobaud_core`

## Requirements
- R1: While reset is high and in the first cycles after it, `locked_o` is 0, `period_o` is 0, and `tick_o` and `strobe_o` are 0.
- R2: A calibration low interval of L synchronized clock cycles, measured from the falling edge to the next rising edge, sets `period_o` to floor(L/8). `locked_o` goes to 1 when the result lies between 1 and 512. Calibration is the byte 80h sent LSB first: eight bit times low, then high.
- R3: A low interval shorter than 8 cycles gives a period of 0. It does not lock, and the block keeps waiting for the next calibration character.
- R4: A low interval of 4104 cycles or more, which is 8 × (512 + 1), overflows the measurement. The block stays unlocked with `period_o` = 0, even after the line returns high, until a new valid calibration completes.
- R5: While locked, a low episode shorter than ten bit periods leaves `locked_o` and `period_o` unchanged. Falling edges of data characters do not start a new measurement.
- R6: While locked, a run of at least 10 × `period_o` consecutive low cycles is a break. It clears `locked_o` and sets `period_o` to 0. The block does not lock again until a new calibration character is measured.
- R7: While locked with the line idle, `tick_o` pulses once every `period_o` cycles. A period of 1 gives a tick on every cycle.
- R8: While locked, `strobe_o` pulses max(1, floor(`period_o`/2)) cycles after each tick. When the period is 2 or more, it never coincides with a tick.
- R9: While unlocked, `tick_o` and `strobe_o` stay 0.
- R10: While `locked_o` stays 1, `period_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw serial line level, idle high |
| period_o | output | 10 | Learned bit period in system clocks; 0 when unlocked |
| locked_o | output | 1 | A valid bit period is held |
| tick_o | output | 1 | One-cycle pulse at each bit boundary |
| strobe_o | output | 1 | One-cycle pulse at the mid-bit sample point |

## Verification
The bench drives calibration characters at rates from one clock per bit up to 512 clocks per bit, including a low interval that is not a multiple of eight. Each case checks the learned period exactly. A design with an off-by-one in the low count, or a divide that rounds up, would report the wrong period here. At the slow end, the bench places low intervals on each side of the 4104-cycle overflow point, so a counter that wraps instead of saturating would lock onto a tiny bogus rate. For break handling, the bench holds the line low just under and then past ten bit periods. It also sends short data-like lows that would measure to a different rate. A block that re-measured on every falling edge, or that broke too early, would change its period or drop lock. Tick spacing and strobe offset are measured at several periods, including 1, 2 and 3, where halving and the minimum of one clock are easiest to get wrong.

// File: rtl/abd_pkg.sv
package abd_pkg;

    // Slowest supported bit period in system clocks.
    localparam int unsigned MAX_DIV  = 512;
    // Bit times the calibration character keeps the line low (power of two).
    localparam int unsigned CAL_BITS = 8;
    // Consecutive low bit times that count as a line break.
    localparam int unsigned BRK_BITS = 10;

    typedef enum logic [1:0] {
        ST_HUNT,   // waiting for the calibration falling edge
        ST_MEAS,   // timing the low interval
        ST_LOCK,   // rate held, watching for break
        ST_WAIT    // dropped: wait for line high before hunting
    } abd_state_e;

    // Mid-bit offset: half the period, never less than one clock.
    function automatic int unsigned half_of(input int unsigned per);
        int unsigned h;
        h = per >> 1;
        return (h == 0) ? 1 : h;
    endfunction

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
    parameter bit IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= IDLE;
            sync_q <= IDLE;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/abd_meter.sv
module abd_meter #(
    parameter int unsigned MAX_DIV  = abd_pkg::MAX_DIV,
    parameter int unsigned CAL_BITS = abd_pkg::CAL_BITS,
    parameter int unsigned BRK_BITS = abd_pkg::BRK_BITS,
    localparam int unsigned PER_W   = $clog2(MAX_DIV + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_s,
    output logic [PER_W-1:0] period_o,
    output logic             locked_o,
    output logic             fall_o
);
    import abd_pkg::*;

    localparam int unsigned LIMIT = CAL_BITS * (MAX_DIV + 1);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam int unsigned SHIFT = $clog2(CAL_BITS);
    localparam int unsigned BRK_W = $clog2(BRK_BITS * MAX_DIV + 1);

    abd_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] quo;
    logic [BRK_W-1:0] lowrun;
    logic [BRK_W-1:0] thr;
    logic [PER_W-1:0] per_q;
    logic             lock_q;
    logic             line_q;
    logic             fall;
    logic             quo_ok;

    assign fall   = line_q & ~line_s;
    assign quo    = cnt >> SHIFT;
    assign quo_ok = (quo != '0);
    assign thr    = BRK_W'(BRK_BITS) * BRK_W'(per_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HUNT;
            cnt    <= '0;
            lowrun <= '0;
            per_q  <= '0;
            lock_q <= 1'b0;
            line_q <= 1'b1;
        end else begin
            line_q <= line_s;
            case (st)
                ST_HUNT: begin
                    if (fall) begin
                        st  <= ST_MEAS;
                        cnt <= CNT_W'(1);
                    end
                end
                ST_MEAS: begin
                    if (!line_s) begin
                        if (cnt == CNT_W'(LIMIT - 1)) st <= ST_WAIT;
                        else                          cnt <= cnt + 1'b1;
                    end else if (quo_ok) begin
                        st     <= ST_LOCK;
                        per_q  <= quo[PER_W-1:0];
                        lock_q <= 1'b1;
                        lowrun <= '0;
                    end else begin
                        st <= ST_HUNT;
                    end
                end
                ST_LOCK: begin
                    if (!line_s) begin
                        if (lowrun == thr - 1'b1) begin
                            st     <= ST_WAIT;
                            per_q  <= '0;
                            lock_q <= 1'b0;
                            lowrun <= '0;
                        end else begin
                            lowrun <= lowrun + 1'b1;
                        end
                    end else begin
                        lowrun <= '0;
                    end
                end
                ST_WAIT: begin
                    if (line_s) st <= ST_HUNT;
                end
                default: st <= ST_HUNT;
            endcase
        end
    end

    assign period_o = per_q;
    assign locked_o = lock_q;
    assign fall_o   = fall;
endmodule

// File: rtl/abd_ticker.sv
module abd_ticker #(
    parameter int unsigned PER_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             locked_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             resync_i,
    output logic             tick_o,
    output logic             strobe_o
);
    logic [PER_W-1:0] pc;
    logic [PER_W-1:0] half_w;
    logic             at_end;

    assign half_w = PER_W'(abd_pkg::half_of(32'(period_i)));
    assign at_end = (pc == period_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)           pc <= '0;
        else if (!locked_i) pc <= '0;
        else if (resync_i)  pc <= '0;
        else if (at_end)    pc <= '0;
        else                pc <= pc + 1'b1;
    end

    assign tick_o   = locked_i & at_end;
    assign strobe_o = locked_i & (pc == half_w - 1'b1);
endmodule

// File: rtl/autobaud_core.sv
module autobaud_core #(
    parameter int unsigned MAX_DIV  = abd_pkg::MAX_DIV,
    parameter int unsigned CAL_BITS = abd_pkg::CAL_BITS,
    parameter int unsigned BRK_BITS = abd_pkg::BRK_BITS,
    localparam int unsigned PER_W   = $clog2(MAX_DIV + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    output logic [PER_W-1:0] period_o,
    output logic             locked_o,
    output logic             tick_o,
    output logic             strobe_o
);
    logic line_s;
    logic fall;

    abd_sync #(.IDLE(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (line_i),
        .q_o (line_s)
    );

    abd_meter #(
        .MAX_DIV  (MAX_DIV),
        .CAL_BITS (CAL_BITS),
        .BRK_BITS (BRK_BITS)
    ) u_meter (
        .clk      (clk),
        .rst      (rst),
        .line_s   (line_s),
        .period_o (period_o),
        .locked_o (locked_o),
        .fall_o   (fall)
    );

    abd_ticker #(.PER_W(PER_W)) u_ticker (
        .clk      (clk),
        .rst      (rst),
        .locked_i (locked_o),
        .period_i (period_o),
        .resync_i (fall & locked_o),
        .tick_o   (tick_o),
        .strobe_o (strobe_o)
    );
endmodule

// File: rtl/abd_chk.sv
module abd_chk #(
    parameter int unsigned PER_W   = 10,
    parameter int unsigned MAX_DIV = 512
) (
    input logic             clk,
    input logic             rst,
    input logic [PER_W-1:0] period_o,
    input logic             locked_o,
    input logic             tick_o,
    input logic             strobe_o
);
    // R9
    quiet_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        !locked_o |-> (!tick_o && !strobe_o));

    // R6
    unlocked_period_chk: assert property (@(posedge clk) disable iff (rst)
        !locked_o |-> (period_o == '0));

    // R2
    period_range_chk: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> (period_o != '0 && 32'(period_o) <= MAX_DIV));

    // R10
    period_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_o && $past(locked_o)) |-> $stable(period_o));

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && period_o > 1 && locked_o) |=> !tick_o);

    // R8
    strobe_apart_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_o && period_o > 1) |-> !(tick_o && strobe_o));
endmodule

bind autobaud_core abd_chk #(.PER_W(PER_W), .MAX_DIV(MAX_DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .period_o (period_o),
    .locked_o (locked_o),
    .tick_o   (tick_o),
    .strobe_o (strobe_o)
);

// File: tb/autobaud_core_tb.sv
module autobaud_core_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       line;
    logic [9:0] period;
    logic       locked;
    logic       tick;
    logic       strobe;

    int checks = 0;
    int fails  = 0;

    autobaud_core u_dut (
        .clk      (clk),
        .rst      (rst),
        .line_i   (line),
        .period_o (period),
        .locked_o (locked),
        .tick_o   (tick),
        .strobe_o (strobe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        line = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(2);
    endtask

    task automatic low_pulse(input int len);
        line = 1'b0;
        cyc(len);
        line = 1'b1;
        cyc(6);
    endtask

    task automatic expect_lock(input string req, input int per);
        chk(locked == 1'b1, req, int'(locked), 1);
        chk(int'(period) == per, req, int'(period), per);
    endtask

    task automatic expect_unlock(input string req);
        chk(locked == 1'b0, req, int'(locked), 0);
        chk(period == '0, req, int'(period), 0);
    endtask

    // R7 / R8: spacing from one tick to the next tick and to the strobe.
    task automatic meas_ticks(input int per);
        int s_at;
        int t_at;
        int hwant;
        bit seen;
        s_at  = -1;
        t_at  = -1;
        seen  = 1'b0;
        hwant = (per / 2 == 0) ? 1 : per / 2;
        for (int g = 0; g < 2 * per + 4 && !seen; g++) begin
            if (tick) seen = 1'b1;
            else cyc(1);
        end
        chk(seen, "R7 tick present", int'(seen), 1);
        for (int k = 1; k <= per + 2; k++) begin
            cyc(1);
            if (strobe && s_at < 0) s_at = k;
            if (tick) begin
                t_at = k;
                break;
            end
        end
        chk(t_at == per, "R7 tick spacing", t_at, per);
        chk(s_at == hwant, "R8 strobe offset", s_at, hwant);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        int rates[10] = '{1, 2, 3, 5, 8, 13, 64, 200, 511, 512};
        int ticks_seen;

        rst  = 1'b1;
        line = 1'b1;
        cyc(2);
        // R1: state during reset
        chk(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        chk(period == '0, "R1 period in reset", int'(period), 0);
        do_reset();
        // R1: state after reset, line idle
        chk(locked == 1'b0, "R1 locked after reset", int'(locked), 0);
        chk(tick == 1'b0 && strobe == 1'b0, "R1 pulses after reset", int'(tick | strobe), 0);

        // R2 sweep: 80h at several rates, eight bit times low
        foreach (rates[i]) begin
            do_reset();
            low_pulse(8 * rates[i]);
            expect_lock("R2 calibrated period", rates[i]);
            if (rates[i] <= 64) meas_ticks(rates[i]);
        end

        // R2: a low count that is not a multiple of eight rounds down
        do_reset();
        low_pulse(8 * 9 + 7);
        expect_lock("R2 round down", 9);

        // R3: too short to give a period, then a valid character still locks
        do_reset();
        low_pulse(7);
        expect_unlock("R3 short low");
        low_pulse(8 * 4);
        expect_lock("R3 relock after short", 4);

        // R4: overflow point and the value just below it
        do_reset();
        low_pulse(4103);
        expect_lock("R4 just below overflow", 512);
        do_reset();
        low_pulse(4104);
        expect_unlock("R4 overflow");
        cyc(2000);
        expect_unlock("R4 stays unlocked");
        low_pulse(8 * 6);
        expect_lock("R4 new calibration", 6);

        // R5: data-like lows while locked must not re-measure or break
        do_reset();
        low_pulse(8 * 5);
        expect_lock("R5 setup", 5);
        low_pulse(30);
        expect_lock("R5 short low ignored", 5);
        low_pulse(47);
        expect_lock("R5 low below break", 5);

        // R6: break at ten bit periods
        do_reset();
        low_pulse(8 * 4);
        expect_lock("R6 setup", 4);
        line = 1'b0;
        cyc(36);
        chk(locked == 1'b1, "R6 not yet break", int'(locked), 1);
        cyc(12);
        expect_unlock("R6 break");
        // R9: no pulses while unlocked
        ticks_seen = 0;
        for (int k = 0; k < 100; k++) begin
            if (tick || strobe) ticks_seen++;
            cyc(1);
        end
        chk(ticks_seen == 0, "R9 silent while unlocked", ticks_seen, 0);
        line = 1'b1;
        cyc(200);
        expect_unlock("R6 no relock without calibration");
        low_pulse(8 * 7);
        expect_lock("R6 relock", 7);
        meas_ticks(7);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule